// File: doc/BRIEF.md
# Multicart PRG bank mapper

A bank-switching controller for a cartridge on an 8-bit console CPU bus. A single write anywhere in the upper half of CPU space (address bit 15 set) loads the whole configuration in one step. Some fields come from the CPU address lines of that write and the rest come from its data byte. The stored configuration and the live CPU address bit 14 together select a 6-bit, 16 KiB program ROM bank. The block forms a 20-bit ROM address from that bank, which reaches up to 1 MiB.

There are four window modes. Two give a switchable low window with a fixed high window, and two give whole-image mappings of 16 KiB or 32 KiB. The block also drives the nametable RAM A10 line from the PPU address, picking horizontal or vertical arrangement. A one-way freeze flag, set by a write, restricts all later writes to the three low bank bits until a synchronous reset clears it.

Top module: `mc_prg_mapper`

## Requirements
- R1: A write with wr_en high and cpu_addr[15]=1 updates the registers on that rising clock edge. A write with cpu_addr[15]=0 changes nothing.
- R2: The low bank field is data[2:0]. The group field is {cpu_addr[4], data[4], data[3]}, with cpu_addr[4] as its MSB. The bank is {group, 3 low bits}, so prg_bank[5:3] equals the group.
- R3: data[5]=0 and data[6]=0: when cpu_addr[14]=0 the bank is {group, low}, and when cpu_addr[14]=1 it is {group, 3'b111}.
- R4: data[5]=0 and data[6]=1: when cpu_addr[14]=0 the bank is {group, low[2:1], 0}, and when cpu_addr[14]=1 it is {group, 3'b111}.
- R5: data[5]=1 and data[6]=0: the bank is {group, low} for either value of cpu_addr[14].
- R6: data[5]=1 and data[6]=1: the bank is {group, low[2:1], cpu_addr[14]}.
- R7: data[7] picks the arrangement. ciram_a10 equals ppu_addr[11] when data[7]=0 (horizontal) and ppu_addr[10] when data[7]=1 (vertical).
- R8: A write with cpu_addr[3]=1 is applied in full and sets the freeze flag. While the flag is set, a write updates only the low bank field, and the group, mode, arrangement and freeze state keep their values.
- R9: Synchronous reset clears every field and the freeze flag. After reset, cpu_addr[14]=0 gives bank 0, cpu_addr[14]=1 gives bank 7, and the arrangement is horizontal.
- R10: cpu_addr[2] has no effect on any output.
- R11: prg_addr = {prg_bank, cpu_addr[13:0]} at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Single-cycle CPU write strobe |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| ppu_addr | input | 14 | PPU address |
| prg_bank | output | 6 | Selected 16 KiB bank |
| prg_addr | output | 20 | Program ROM address |
| ciram_a10 | output | 1 | Nametable RAM A10 select |

## Verification
Any wrong stored field shows up on prg_bank within half a cycle after the write edge, because the bank path is purely combinational from the registers and cpu_addr[14]. A freeze flag that is set or cleared at the wrong time stays hidden until the next write. That write then changes the group or mode when it should not, or fails to when it should. For this reason every freeze check performs a second write and then reads both windows. A fault in the arrangement bit appears only when ppu_addr[10] and ppu_addr[11] differ, so the bench drives them to opposite values.

// File: rtl/mc_prg_mapper.sv
module mc_prg_mapper #(
  parameter int LOW_W = 3,
  parameter int GRP_W = 3,
  parameter int WIN_W = 14
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [15:0]                  cpu_addr,
  input  logic [7:0]                   cpu_data,
  input  logic [13:0]                  ppu_addr,
  output logic [LOW_W+GRP_W-1:0]       prg_bank,
  output logic [LOW_W+GRP_W+WIN_W-1:0] prg_addr,
  output logic                         ciram_a10
);
  logic [LOW_W-1:0] low_q;
  logic [GRP_W-1:0] grp_q;
  logic             nrom_q, tsp_q, vert_q, frz_q;
  logic             hit;
  logic [LOW_W-1:0] low_sel;

  assign hit = wr_en && cpu_addr[15];

  always_ff @(posedge clk) begin
    if (rst) begin
      low_q  <= '0;
      grp_q  <= '0;
      nrom_q <= 1'b0;
      tsp_q  <= 1'b0;
      vert_q <= 1'b0;
      frz_q  <= 1'b0;
    end else if (hit) begin
      low_q <= cpu_data[LOW_W-1:0];
      if (!frz_q) begin
        grp_q  <= {cpu_addr[4], cpu_data[4], cpu_data[3]};
        nrom_q <= cpu_data[5];
        tsp_q  <= cpu_data[6];
        vert_q <= cpu_data[7];
        frz_q  <= cpu_addr[3];
      end
    end
  end

  always_comb begin
    unique case ({nrom_q, tsp_q})
      2'b00:   low_sel = cpu_addr[14] ? '1 : low_q;
      2'b01:   low_sel = cpu_addr[14] ? '1 : {low_q[LOW_W-1:1], 1'b0};
      2'b10:   low_sel = low_q;
      default: low_sel = {low_q[LOW_W-1:1], cpu_addr[14]};
    endcase
  end

  assign prg_bank  = {grp_q, low_sel};
  assign prg_addr  = {prg_bank, cpu_addr[WIN_W-1:0]};
  assign ciram_a10 = vert_q ? ppu_addr[10] : ppu_addr[11];
endmodule

module mc_prg_mapper_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_data,
  input logic [5:0]  prg_bank,
  input logic [19:0] prg_addr,
  input logic        frz_q
);
  // R11
  addr_concat_chk: assert property (@(posedge clk) prg_addr[13:0] == cpu_addr[13:0]);
  // R1
  low_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !cpu_addr[15]) |=> $stable(prg_bank[5:3]));
  // R8
  freeze_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    frz_q |=> frz_q);
  // R8
  freeze_group_chk: assert property (@(posedge clk) disable iff (rst)
    (frz_q && $stable(cpu_addr[14])) |=> $stable(prg_bank[5:3]));
  // R9
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!frz_q && prg_bank[5:3] == 3'd0));
endmodule

bind mc_prg_mapper mc_prg_mapper_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
  .prg_bank(prg_bank), .prg_addr(prg_addr), .frz_q(frz_q)
);

// File: tb/mc_prg_mapper_test.sv
module mc_prg_mapper_test;
  localparam time CLK_P = 10ns;
  logic clk = 0, rst = 1, wr_en = 0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 8'h00;
  logic [13:0] ppu_addr = 14'h0800;
  logic [5:0]  prg_bank;
  logic [19:0] prg_addr;
  logic        ciram_a10;
  int n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  mc_prg_mapper uut (.clk(clk), .rst(rst), .wr_en(wr_en), .cpu_addr(cpu_addr),
    .cpu_data(cpu_data), .ppu_addr(ppu_addr), .prg_bank(prg_bank),
    .prg_addr(prg_addr), .ciram_a10(ciram_a10));

  // {write addr, write data, bank @A14=0, bank @A14=1, mirror (ppu A11=1,A10=0)}
  localparam int NV = 10;
  localparam logic [36:0] VEC [NV] = '{
    {16'h8000, 8'h05, 6'd5,  6'd7,  1'b1},   // R3
    {16'h8000, 8'h10, 6'd16, 6'd23, 1'b1},   // R2
    {16'h8010, 8'h18, 6'd56, 6'd63, 1'b1},   // R2
    {16'hC000, 8'h1D, 6'd29, 6'd31, 1'b1},   // R2 R3
    {16'h8000, 8'h47, 6'd6,  6'd7,  1'b1},   // R4
    {16'h8000, 8'h25, 6'd5,  6'd5,  1'b1},   // R5
    {16'h8000, 8'h66, 6'd6,  6'd7,  1'b1},   // R6
    {16'h8010, 8'h61, 6'd32, 6'd33, 1'b1},   // R6
    {16'h8000, 8'h80, 6'd0,  6'd7,  1'b0},   // R7
    {16'h8004, 8'hA3, 6'd3,  6'd3,  1'b0}    // R10
  };

  task automatic chk(string req, logic [19:0] act, logic [19:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0; cpu_addr = 16'h8000;
  endtask

  task automatic look(string req, logic [5:0] b0, logic [5:0] b1);
    cpu_addr = 16'h8123; #1; chk(req, prg_bank, b0);
    chk("R11", prg_addr, {b0, 14'h0123});
    cpu_addr = 16'hC123; #1; chk(req, prg_bank, b1);
  endtask

  initial begin
    #(CLK_P*5000); n_fail++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk); rst = 0;
    look("R9", 6'd0, 6'd7); chk("R9", ciram_a10, 1'b1);
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][36:21], VEC[i][20:13]);
      look("R2-vec", VEC[i][12:7], VEC[i][6:1]);
      chk("R7", ciram_a10, VEC[i][0]);
    end
    for (int g = 0; g < 8; g++)
      for (int l = 0; l < 8; l++) begin
        wr({11'h400, g[2], 4'h0}, {3'b001, g[1:0], l[2:0]});
        look("R5 sweep", {g[2:0], l[2:0]}, {g[2:0], l[2:0]});
      end
    wr(16'h8000, 8'h05);
    wr(16'h7FFF, 8'hFF);
    look("R1", 6'd5, 6'd7);
    wr(16'h8008, 8'h13);
    look("R8", 6'd19, 6'd23);
    wr(16'h8010, 8'hE7);
    look("R8", 6'd23, 6'd23);
    chk("R8", ciram_a10, 1'b1);
    wr(16'h8000, 8'h02);
    look("R8", 6'd18, 6'd23);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    look("R9", 6'd0, 6'd7);
    wr(16'h8000, 8'h10);
    look("R9", 6'd16, 6'd23);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule